// File: doc/BRIEF.md
# Timer Capture Unit with Edge Prescaler

The block watches one asynchronous input pin and, when a chosen event occurs on it, copies the current value of one of two 16-bit free-running timers into a 16-bit capture register and raises an interrupt flag. Four event settings are available: every falling edge, every rising edge, every fourth rising edge and every sixteenth rising edge. A 4-bit mode field turns the unit on and picks the setting. A select bit picks which timer is sampled.

The pin is brought into the clock domain by a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier. A shared prescaler counter counts qualifying edges. It is cleared only while the unit is off or in a non-capture mode. Changing the mode field directly from one capture setting to another therefore keeps the partial count, so the first capture after such a change can come early. The flag stays set until software pulses the clear strobe.

Top module: `tcap_unit`

## Requirements
- R1: After reset, `cap_o` is 0 and `flag_o` is 0.
- R2: A pin level change present before clock edge n is acted on at edge n+2. The capture register and flag take their new values at that edge.
- R3: With `mode_i` = 4'b0100, every falling edge of the synchronized pin captures. Rising edges capture nothing.
- R4: With `mode_i` = 4'b0101, every rising edge of the synchronized pin captures. Falling edges capture nothing.
- R5: With `mode_i` = 4'b0110 or 4'b0111, a counter counts rising edges modulo 16. A capture happens on the edge where the count before the edge is 3 modulo 4 (for 0110) or is 15 (for 0111). Starting from a cleared counter, this gives every 4th or every 16th rising edge.
- R6: A capture loads `tmr_a_i` when `tmr_sel_i` = 0 and `tmr_b_i` when `tmr_sel_i` = 1, using the values present at the capture edge.
- R7: A capture sets `flag_o`. The flag stays set until `flag_clr_i` is high at a clock edge. If a clear and a capture coincide at the same edge, the flag stays set.
- R8: Any `mode_i` whose bits [3:2] are not 2'b01 (including 4'b0000, off) clears the edge counter. Edges in such a mode leave `cap_o` and `flag_o` unchanged.
- R9: Changing `mode_i` directly between capture settings does not clear the edge counter. For example, 3 rising edges under 4'b0111 followed by a switch to 4'b0110 makes the next rising edge capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous event pin |
| tmr_a_i | input | 16 | First timer value |
| tmr_b_i | input | 16 | Second timer value |
| tmr_sel_i | input | 1 | Timer select: 0 first, 1 second |
| mode_i | input | 4 | Mode field (off / capture settings) |
| flag_clr_i | input | 1 | Flag clear strobe |
| cap_o | output | 16 | Capture register |
| flag_o | output | 1 | Interrupt flag |

## Verification
On every cycle, assertions check the following:
- the edge detector never reports both polarities at once;
- captures occur only in capture modes;
- the edge counter is zero one cycle after a non-capture mode;
- each capture sets the flag and loads the selected timer;
- the register holds between captures;
- an uncontested clear drops the flag.

Only the bench scenarios can show the rest: the exact event ratios, the two-edge pin latency, the stale count kept across a direct switch between settings, and a clear losing to a coincident capture. These are compared each cycle against a behavioural model.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    RATE_FALL  = 2'b00,
    RATE_RISE  = 2'b01,
    RATE_DIV_S = 2'b10,
    RATE_DIV_L = 2'b11
  } rate_e;

  localparam logic [1:0] CAP_GROUP = 2'b01;
endpackage

// File: rtl/tcap_sync_edge.sv
module tcap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o =  sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] &  prev_q;

  // R2: only one edge polarity per cycle
  a_r2_one_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/tcap_prescaler.sv
module tcap_prescaler
  import tcap_pkg::*;
#(
  parameter int DIV_S = 4,
  parameter int DIV_L = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cap_en_i,
  input  rate_e rate_i,
  input  logic  rise_i,
  input  logic  fall_i,
  output logic  evt_o
);
  localparam int CNT_W = $clog2(DIV_L);
  localparam int S_W   = $clog2(DIV_S);

  logic [CNT_W-1:0] cnt_q;
  logic             edge_sel;
  logic             fire;

  always_comb begin
    edge_sel = (rate_i == RATE_FALL) ? fall_i : rise_i;
    unique case (rate_i)
      RATE_FALL,
      RATE_RISE:  fire = 1'b1;
      RATE_DIV_S: fire = &cnt_q[S_W-1:0];
      default:    fire = &cnt_q;
    endcase
  end

  // count survives direct changes between capture settings
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!cap_en_i)           cnt_q <= '0;
    else if (edge_sel)            cnt_q <= cnt_q + CNT_W'(1);
  end

  assign evt_o = cap_en_i & edge_sel & fire;

  // R8: events only in capture modes, counter cleared otherwise
  a_r8_evt_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> cap_en_i);
  a_r8_cnt_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> (cnt_q == '0));
endmodule

// File: rtl/tcap_latch.sv
module tcap_latch #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  logic          sel_i,
  input  logic [TW-1:0] tmr_a_i,
  input  logic [TW-1:0] tmr_b_i,
  input  logic          clr_i,
  output logic [TW-1:0] cap_o,
  output logic          flag_o
);
  logic [TW-1:0] src;

  assign src = sel_i ? tmr_b_i : tmr_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_o <= '0;
    else if (evt_i) cap_o <= src;
  end

  // event beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (evt_i)   flag_o <= 1'b1;
    else if (clr_i)   flag_o <= 1'b0;
  end

  a_r6_loads_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> (cap_o == $past(sel_i ? tmr_b_i : tmr_a_i)));
  a_r7_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o);
  a_r7_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !flag_o);
  a_r8_cap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(cap_o));
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_S       = 4,
  parameter int DIV_L       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_i,
  input  logic [TW-1:0] tmr_a_i,
  input  logic [TW-1:0] tmr_b_i,
  input  logic          tmr_sel_i,
  input  logic [3:0]    mode_i,
  input  logic          flag_clr_i,
  output logic [TW-1:0] cap_o,
  output logic          flag_o
);
  logic  rise, fall, evt, cap_en;
  rate_e rate;

  assign cap_en = (mode_i[3:2] == CAP_GROUP);
  assign rate   = rate_e'(mode_i[1:0]);

  tcap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tcap_prescaler #(.DIV_S(DIV_S), .DIV_L(DIV_L)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (cap_en),
    .rate_i   (rate),
    .rise_i   (rise),
    .fall_i   (fall),
    .evt_o    (evt)
  );

  tcap_latch #(.TW(TW)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .sel_i   (tmr_sel_i),
    .tmr_a_i (tmr_a_i),
    .tmr_b_i (tmr_b_i),
    .clr_i   (flag_clr_i),
    .cap_o   (cap_o),
    .flag_o  (flag_o)
  );

  // R1: quiet after reset
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!flag_o && cap_o == '0));
endmodule

// File: tb/tcap_unit_tb.sv
module tcap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] tmr_a = '0, tmr_b = '0;
  logic        tsel = 1'b0;
  logic [3:0]  mode = 4'b0000;
  logic        clr = 1'b0;
  logic [15:0] cap;
  logic        flag;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  tcap_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .tmr_a_i(tmr_a), .tmr_b_i(tmr_b),
    .tmr_sel_i(tsel), .mode_i(mode), .flag_clr_i(clr), .cap_o(cap), .flag_o(flag)
  );

  // behavioural model
  bit   hist[$] = '{0, 0, 0};
  int   ecount = 0;
  int   m_cap = 0;
  bit   m_flag = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      hist = '{0, 0, 0}; ecount = 0; m_cap = 0; m_flag = 0;
    end else begin
      bit now_lvl, old_lvl, rising, falling, counts, hit;
      now_lvl = hist[1]; old_lvl = hist[2];
      rising  = now_lvl && !old_lvl;
      falling = !now_lvl && old_lvl;
      hit = 0;
      if (mode[3:2] != 2'b01) ecount = 0;
      else begin
        counts = (mode[1:0] == 2'b00) ? falling : rising;
        if (counts) begin
          case (mode[1:0])
            2'b10:   hit = (ecount % 4) == 3;
            2'b11:   hit = (ecount % 16) == 15;
            default: hit = 1;
          endcase
          ecount = (ecount + 1) % 16;
        end
      end
      if (hit) begin
        m_cap = tsel ? int'(tmr_b) : int'(tmr_a);
        m_flag = 1;
      end else if (clr) m_flag = 0;
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check({tag, " cap"}, int'(cap), m_cap);
      check({tag, " flag"}, int'(flag), int'(m_flag));
      tmr_a <= tmr_a + 16'd1;
      tmr_b <= tmr_b + 16'd37;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; cyc(3);
      pin = 1'b0; cyc(3);
    end
  endtask

  task automatic strobe_clr();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  initial begin
    tag = "R1";
    cyc(3);
    check("R1 cap", int'(cap), 0);
    check("R1 flag", int'(flag), 0);
    rst_ni = 1'b1;
    cyc(2);

    tag = "R4"; mode = 4'b0101; pulse(3);
    check("R4 flag", int'(flag), 1);
    tag = "R7"; strobe_clr(); cyc(1);
    check("R7 cleared", int'(flag), 0);
    tag = "R6"; tsel = 1'b1; pulse(2); tsel = 1'b0; strobe_clr();

    tag = "R2"; pin = 1'b1; cyc(1);
    check("R2 edge n", int'(flag), 0);
    cyc(1);
    check("R2 edge n+1", int'(flag), 0);
    cyc(1);
    check("R2 edge n+2", int'(flag), 1);
    pin = 1'b0; cyc(3); strobe_clr();

    tag = "R3"; mode = 4'b0100; pulse(3); strobe_clr();
    pin = 1'b1; cyc(4);
    check("R3 rise ignored", int'(flag), 0);
    pin = 1'b0; cyc(4); strobe_clr();

    tag = "R5"; mode = 4'b0000; cyc(2); mode = 4'b0110;
    pulse(3);
    check("R5 div4 early", int'(flag), 0);
    pulse(1);
    check("R5 div4 fire", int'(flag), 1);
    strobe_clr(); pulse(6);
    mode = 4'b0000; cyc(2); strobe_clr(); mode = 4'b0111;
    pulse(15);
    check("R5 div16 early", int'(flag), 0);
    pulse(1);
    check("R5 div16 fire", int'(flag), 1);
    strobe_clr(); pulse(20); strobe_clr();

    tag = "R8"; mode = 4'b0000; cyc(2); strobe_clr(); pulse(4);
    check("R8 off", int'(flag), 0);
    mode = 4'b1001; pulse(4);
    check("R8 non-capture", int'(flag), 0);

    tag = "R9"; mode = 4'b0111; pulse(3);
    check("R9 pre", int'(flag), 0);
    mode = 4'b0110; pulse(1);
    check("R9 stale count", int'(flag), 1);
    strobe_clr();

    tag = "R7"; mode = 4'b0101;
    pin = 1'b1; cyc(2); clr = 1'b1; cyc(1); clr = 1'b0;
    check("R7 event beats clear", int'(flag), 1);
    pin = 1'b0; cyc(4);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule